// File: doc/BRIEF.md
# Pin Function Crossbar

This block sits between a set of on-chip peripherals and the eight pins of one digital port. Each pin has a 5-bit selector register that software writes over a simple register bus. The selector decides which peripheral output drives the pin, which peripheral input sees the pin's level, whether the port's direction bit or the peripheral sets the output enable, and whether the pin works as open-drain or as analog.

Peripherals appear as generic signal vectors: two comparator results, a converter clock, a monitor flag, the system clock, seven timer compare outputs, and six bidirectional serial lines, each with its own data and enable. The block returns a timer clock, a DMA trigger, a timer high-impedance request, seven capture inputs and six serial inputs. For each pin it produces an output value, an output enable, an input-buffer enable and an open-drain flag for the pad.

Top module: `pin_xbar`

## Requirements
- R1: After reset, pin p's selector holds the code given by DEFAULT_MAP. The default map is 4+p, so pins 0..7 read back 4..11.
- R2: A write to a selector takes effect at the next rising clock edge. Only the low 5 bits are stored and bits 7:5 always read back 0, so writing 0xFF reads back 31. The read port returns the selector addressed by rd_addr_i.
- R3: Code 31 (analog) forces output enable 0, input-buffer enable 0, output value 0 and open-drain 0, and the pin feeds no input function.
- R4: Codes 19..30 drive the output value 0, take the output enable from dir_i, and feed no input function.
- R5: Code 0 drives cmp_a_i onto the pin, with the output enable from dir_i, and feeds no input function.
- R6: Code 1 feeds tmr_clk_o and drives conv_clk_i. Code 2 feeds dma_trig_o and drives mon_i. Code 3 feeds tmr_hiz_o and drives 0. All three take the output enable from dir_i.
- R7: Codes 4..10 map timer channel k = code-4. The pin feeds tmr_cap_o[k] and drives tmr_cmp_i[k], with the output enable from dir_i.
- R8: Codes 11..16 map serial line k = code-11. The pin feeds ser_in_o[k], and ser_oe_i[k] replaces dir_i as the output enable. Apart from codes 14 and 15, the pin drives ser_out_i[k].
- R9: Codes 14 and 15 are open-drain. The open-drain flag is 1 and the output value is 0. The output enable is ser_oe_i[k] AND NOT ser_out_i[k], so the pin only pulls low or releases.
- R10: Code 17 drives cmp_b_i and code 18 drives sys_clk_i. Both take the output enable from dir_i and feed no input function.
- R11: Each input function equals the OR of pin_i over all pins whose selector maps that function. It is 0 when no pin maps it.
- R12: The input-buffer enable is 1 for every code except 31. The open-drain flag is 0 for every code except 14 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Selector write strobe |
| wr_addr_i | input | 3 | Pin index to write |
| wr_data_i | input | 8 | Write data, low 5 bits kept |
| rd_addr_i | input | 3 | Pin index to read |
| rd_data_o | output | 8 | Selector of addressed pin, zero-extended |
| dir_i | input | 8 | Per-pin direction for non-peripheral codes |
| pin_i | input | 8 | Pin levels from the pads |
| cmp_a_i | input | 1 | First comparator result |
| cmp_b_i | input | 1 | Second comparator result |
| conv_clk_i | input | 1 | Converter clock |
| mon_i | input | 1 | Supply monitor flag |
| sys_clk_i | input | 1 | System clock to export |
| tmr_cmp_i | input | 7 | Timer compare outputs |
| ser_out_i | input | 6 | Serial line output data |
| ser_oe_i | input | 6 | Serial line output enables |
| tmr_clk_o | output | 1 | Timer external clock input |
| dma_trig_o | output | 1 | DMA trigger input |
| tmr_hiz_o | output | 1 | Timer high-impedance request |
| tmr_cap_o | output | 7 | Timer capture inputs |
| ser_in_o | output | 6 | Serial line input data |
| pin_out_o | output | 8 | Pad output value |
| pin_oe_o | output | 8 | Pad output enable |
| pin_ie_o | output | 8 | Pad input-buffer enable |
| pin_od_o | output | 8 | Pad open-drain flag |

## Verification
The hardest case to reach is an input function fed by several pins at once, because the OR only shows up when two or more selectors hold the same code while their pin levels differ. The stimulus first writes code 1 into every pin and sweeps pin_i through one-hot, mixed and all-zero values. It then runs a long phase of random 8-bit writes to random pins, which in time lands many codes on several pins together and hits the reserved, analog and open-drain codes, including writes with the upper bits set. A behavioural model checks every output against these settings on every cycle.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int SEL_W  = 5;
  localparam int TMR_CH = 7;
  localparam int SER_CH = 6;

  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t SEL_CMP_A    = 5'd0;
  localparam sel_t SEL_CLK      = 5'd1;
  localparam sel_t SEL_TRIG     = 5'd2;
  localparam sel_t SEL_HIZ      = 5'd3;
  localparam sel_t SEL_TMR0     = 5'd4;
  localparam sel_t SEL_TMR_LAST = 5'd10;
  localparam sel_t SEL_SER0     = 5'd11;
  localparam sel_t SEL_OD_CLK   = 5'd14;
  localparam sel_t SEL_OD_DAT   = 5'd15;
  localparam sel_t SEL_SER_LAST = 5'd16;
  localparam sel_t SEL_CMP_B    = 5'd17;
  localparam sel_t SEL_SYSCLK   = 5'd18;
  localparam sel_t SEL_ANALOG   = 5'd31;

  // input function slots
  localparam int IN_CLK  = 0;
  localparam int IN_TRIG = 1;
  localparam int IN_HIZ  = 2;
  localparam int IN_CAP0 = 3;
  localparam int IN_SER0 = IN_CAP0 + TMR_CH;
  localparam int IN_NUM  = IN_SER0 + SER_CH;

  typedef struct packed {
    logic out;
    logic oe;
    logic ie;
    logic od;
  } pad_ctl_t;

  function automatic logic [IN_NUM-1:0] in_decode(sel_t c);
    logic [IN_NUM-1:0] v;
    v = '0;
    if (c == SEL_CLK)  v[IN_CLK]  = 1'b1;
    if (c == SEL_TRIG) v[IN_TRIG] = 1'b1;
    if (c == SEL_HIZ)  v[IN_HIZ]  = 1'b1;
    if (c >= SEL_TMR0 && c <= SEL_TMR_LAST)
      v[IN_CAP0 + (int'(c) - int'(SEL_TMR0))] = 1'b1;
    if (c >= SEL_SER0 && c <= SEL_SER_LAST)
      v[IN_SER0 + (int'(c) - int'(SEL_SER0))] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pin_xbar_regs.sv
module pin_xbar_regs
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter logic [NUM_PINS*SEL_W-1:0] DEFAULT_MAP = '0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic [NUM_PINS*SEL_W-1:0] map_o
);
  localparam int PAD_W = DATA_W - SEL_W;

  sel_t wr_sel;
  logic unused_hi;
  assign wr_sel    = wr_data_i[SEL_W-1:0];
  assign unused_hi = ^wr_data_i[DATA_W-1:SEL_W];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_reg
    sel_t sel_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        sel_q <= DEFAULT_MAP[p*SEL_W +: SEL_W];
      else if (wr_en_i && int'(wr_addr_i) == p)
        sel_q <= wr_sel;
    end
    assign map_o[p*SEL_W +: SEL_W] = sel_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (int'(rd_addr_i) == p)
        rd_data_o = {{PAD_W{1'b0}}, map_o[p*SEL_W +: SEL_W]};
  end
endmodule

// File: rtl/pin_xbar_pad_mux.sv
module pin_xbar_pad_mux
  import pin_xbar_pkg::*;
(
  input  sel_t              sel_i,
  input  logic              dir_i,
  input  logic              cmp_a_i,
  input  logic              cmp_b_i,
  input  logic              conv_clk_i,
  input  logic              mon_i,
  input  logic              sys_clk_i,
  input  logic [TMR_CH-1:0] tmr_cmp_i,
  input  logic [SER_CH-1:0] ser_out_i,
  input  logic [SER_CH-1:0] ser_oe_i,
  output pad_ctl_t          ctl_o
);
  logic in_tmr, in_ser, is_od;
  int   tmr_idx, ser_idx;

  assign in_tmr  = (sel_i >= SEL_TMR0) && (sel_i <= SEL_TMR_LAST);
  assign in_ser  = (sel_i >= SEL_SER0) && (sel_i <= SEL_SER_LAST);
  assign is_od   = (sel_i == SEL_OD_CLK) || (sel_i == SEL_OD_DAT);
  assign tmr_idx = int'(sel_i) - int'(SEL_TMR0);
  assign ser_idx = int'(sel_i) - int'(SEL_SER0);

  always_comb begin
    ctl_o     = '0;
    ctl_o.ie  = 1'b1;
    ctl_o.oe  = dir_i;
    if (sel_i == SEL_ANALOG) begin
      ctl_o.ie = 1'b0;
      ctl_o.oe = 1'b0;
    end else if (in_tmr) begin
      for (int k = 0; k < TMR_CH; k++)
        if (tmr_idx == k) ctl_o.out = tmr_cmp_i[k];
    end else if (in_ser) begin
      for (int k = 0; k < SER_CH; k++) begin
        if (ser_idx == k) begin
          if (is_od) begin
            // pull low or release only
            ctl_o.od  = 1'b1;
            ctl_o.out = 1'b0;
            ctl_o.oe  = ser_oe_i[k] & ~ser_out_i[k];
          end else begin
            ctl_o.out = ser_out_i[k];
            ctl_o.oe  = ser_oe_i[k];
          end
        end
      end
    end else begin
      unique case (sel_i)
        SEL_CMP_A:  ctl_o.out = cmp_a_i;
        SEL_CLK:    ctl_o.out = conv_clk_i;
        SEL_TRIG:   ctl_o.out = mon_i;
        SEL_CMP_B:  ctl_o.out = cmp_b_i;
        SEL_SYSCLK: ctl_o.out = sys_clk_i;
        default:    ctl_o.out = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pin_xbar_in_route.sv
module pin_xbar_in_route
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic [NUM_PINS*SEL_W-1:0] map_i,
  input  logic [NUM_PINS-1:0]       pin_i,
  output logic [IN_NUM-1:0]         fn_o
);
  logic [NUM_PINS-1:0][IN_NUM-1:0] hit;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_hit
    assign hit[p] = pin_i[p] ? in_decode(map_i[p*SEL_W +: SEL_W]) : '0;
  end

  always_comb begin
    fn_o = '0;
    for (int p = 0; p < NUM_PINS; p++) fn_o = fn_o | hit[p];
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 8,
  parameter logic [NUM_PINS*SEL_W-1:0] DEFAULT_MAP =
    {5'd11, 5'd10, 5'd9, 5'd8, 5'd7, 5'd6, 5'd5, 5'd4},
  localparam int ADDR_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                cmp_a_i,
  input  logic                cmp_b_i,
  input  logic                conv_clk_i,
  input  logic                mon_i,
  input  logic                sys_clk_i,
  input  logic [TMR_CH-1:0]   tmr_cmp_i,
  input  logic [SER_CH-1:0]   ser_out_i,
  input  logic [SER_CH-1:0]   ser_oe_i,
  output logic                tmr_clk_o,
  output logic                dma_trig_o,
  output logic                tmr_hiz_o,
  output logic [TMR_CH-1:0]   tmr_cap_o,
  output logic [SER_CH-1:0]   ser_in_o,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_ie_o,
  output logic [NUM_PINS-1:0] pin_od_o
);
  logic [NUM_PINS*SEL_W-1:0] map_flat;
  logic [IN_NUM-1:0]         in_fn;

  pin_xbar_regs #(
    .NUM_PINS    (NUM_PINS),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .DEFAULT_MAP (DEFAULT_MAP)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .map_o     (map_flat)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    pad_ctl_t ctl;
    pin_xbar_pad_mux u_mux (
      .sel_i      (map_flat[p*SEL_W +: SEL_W]),
      .dir_i      (dir_i[p]),
      .cmp_a_i    (cmp_a_i),
      .cmp_b_i    (cmp_b_i),
      .conv_clk_i (conv_clk_i),
      .mon_i      (mon_i),
      .sys_clk_i  (sys_clk_i),
      .tmr_cmp_i  (tmr_cmp_i),
      .ser_out_i  (ser_out_i),
      .ser_oe_i   (ser_oe_i),
      .ctl_o      (ctl)
    );
    assign pin_out_o[p] = ctl.out;
    assign pin_oe_o[p]  = ctl.oe;
    assign pin_ie_o[p]  = ctl.ie;
    assign pin_od_o[p]  = ctl.od;
  end

  pin_xbar_in_route #(.NUM_PINS(NUM_PINS)) u_route (
    .map_i (map_flat),
    .pin_i (pin_i),
    .fn_o  (in_fn)
  );

  assign tmr_clk_o  = in_fn[IN_CLK];
  assign dma_trig_o = in_fn[IN_TRIG];
  assign tmr_hiz_o  = in_fn[IN_HIZ];
  assign tmr_cap_o  = in_fn[IN_CAP0 +: TMR_CH];
  assign ser_in_o   = in_fn[IN_SER0 +: SER_CH];
endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_en_i,
  input logic [ADDR_W-1:0]         wr_addr_i,
  input logic [DATA_W-1:0]         wr_data_i,
  input logic [DATA_W-1:0]         rd_data_o,
  input logic [NUM_PINS*SEL_W-1:0] map_flat,
  input logic [NUM_PINS-1:0]       pin_out_o,
  input logic [NUM_PINS-1:0]       pin_oe_o,
  input logic [NUM_PINS-1:0]       pin_ie_o,
  input logic [NUM_PINS-1:0]       pin_od_o,
  input logic                      tmr_clk_o
);
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  sel_t              data_q;
  sel_t              sel_at_q;
  logic              clk_mapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wr_q   <= wr_en_i && (int'(wr_addr_i) < NUM_PINS);
      addr_q <= wr_addr_i;
      data_q <= wr_data_i[SEL_W-1:0];
    end
  end

  always_comb begin
    sel_at_q   = '0;
    clk_mapped = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (int'(addr_q) == p) sel_at_q = map_flat[p*SEL_W +: SEL_W];
      if (map_flat[p*SEL_W +: SEL_W] == SEL_CLK) clk_mapped = 1'b1;
    end
  end

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> sel_at_q == data_q);

  assert_rd_hi_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:SEL_W] == '0);

  assert_unmapped_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_mapped |-> !tmr_clk_o);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    sel_t s;
    assign s = map_flat[p*SEL_W +: SEL_W];

    assert_analog_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s == SEL_ANALOG |-> !pin_oe_o[p] && !pin_ie_o[p]);

    assert_reserved_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s >= 5'd19 && s <= 5'd30) |-> !pin_out_o[p]);

    assert_od_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_od_o[p] |-> !pin_out_o[p] && (s == SEL_OD_CLK || s == SEL_OD_DAT));

    assert_ie_only_analog_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pin_ie_o[p] |-> s == SEL_ANALOG);
  end
endmodule

bind pin_xbar pin_xbar_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .map_flat  (map_flat),
  .pin_out_o (pin_out_o),
  .pin_oe_o  (pin_oe_o),
  .pin_ie_o  (pin_ie_o),
  .pin_od_o  (pin_od_o),
  .tmr_clk_o (tmr_clk_o)
);

// File: tb/pin_xbar_test.sv
`timescale 1ns/1ps
module pin_xbar_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] dir = '0, pin = '0;
  logic       cmp_a = 0, cmp_b = 0, conv_clk = 0, mon = 0, sys_clk = 0;
  logic [6:0] tmr_cmp = '0;
  logic [5:0] ser_out = '0, ser_oe = '0;
  logic       tmr_clk, dma_trig, tmr_hiz;
  logic [6:0] tmr_cap;
  logic [5:0] ser_in;
  logic [7:0] pout, poe, pie, pod;

  int checks = 0, errors = 0;
  int ref_map[8];
  bit cmp_en = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_xbar uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .dir_i(dir), .pin_i(pin), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b),
    .conv_clk_i(conv_clk), .mon_i(mon), .sys_clk_i(sys_clk),
    .tmr_cmp_i(tmr_cmp), .ser_out_i(ser_out), .ser_oe_i(ser_oe),
    .tmr_clk_o(tmr_clk), .dma_trig_o(dma_trig), .tmr_hiz_o(tmr_hiz),
    .tmr_cap_o(tmr_cap), .ser_in_o(ser_in), .pin_out_o(pout),
    .pin_oe_o(poe), .pin_ie_o(pie), .pin_od_o(pod)
  );

  // reference selector state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int p = 0; p < 8; p++) ref_map[p] = 4 + p;
    else if (wr_en) ref_map[wr_addr] = wr_data & 31;
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int c);
    if (c == 31) return "R3";
    if (c >= 19) return "R4";
    if (c == 0) return "R5";
    if (c <= 3) return "R6";
    if (c <= 10) return "R7";
    if (c == 14 || c == 15) return "R9";
    if (c <= 16) return "R8";
    return "R10";
  endfunction

  task automatic compare();
    int ein[16];
    for (int f = 0; f < 16; f++) ein[f] = 0;
    for (int p = 0; p < 8; p++) begin
      int c = ref_map[p];
      int eo = 0, ee = dir[p], ei = 1, ed = 0;
      if (c == 0) eo = cmp_a;
      else if (c == 1) eo = conv_clk;
      else if (c == 2) eo = mon;
      else if (c >= 4 && c <= 10) eo = tmr_cmp[c-4];
      else if (c >= 11 && c <= 16) begin
        if (c == 14 || c == 15) begin
          ed = 1; eo = 0; ee = ser_oe[c-11] & ~ser_out[c-11];
        end else begin
          eo = ser_out[c-11]; ee = ser_oe[c-11];
        end
      end
      else if (c == 17) eo = cmp_b;
      else if (c == 18) eo = sys_clk;
      else if (c == 31) begin ee = 0; ei = 0; end
      if (c >= 1 && c <= 16 && pin[p]) ein[c-1] = 1;
      chk(tag_of(c), $sformatf("pin%0d out", p), pout[p], eo);
      chk(tag_of(c), $sformatf("pin%0d oe", p), poe[p], ee);
      chk((c == 31) ? "R3" : "R12", $sformatf("pin%0d ie", p), pie[p], ei);
      chk((c == 14 || c == 15) ? "R9" : "R12", $sformatf("pin%0d od", p), pod[p], ed);
    end
    chk("R11", "tmr_clk", tmr_clk, ein[0]);
    chk("R11", "dma_trig", dma_trig, ein[1]);
    chk("R11", "tmr_hiz", tmr_hiz, ein[2]);
    for (int k = 0; k < 7; k++) chk("R11", $sformatf("cap%0d", k), tmr_cap[k], ein[3+k]);
    for (int k = 0; k < 6; k++) chk("R11", $sformatf("ser_in%0d", k), ser_in[k], ein[10+k]);
    chk("R2", "rd_data", rd_data, ref_map[rd_addr]);
  endtask

  always @(negedge clk) if (rst_n && cmp_en && !done) compare();

  task automatic rand_inputs();
    dir = 8'($urandom); pin = 8'($urandom);
    {cmp_a, cmp_b, conv_clk, mon, sys_clk} = 5'($urandom);
    tmr_cmp = 7'($urandom); ser_out = 6'($urandom); ser_oe = 6'($urandom);
    rd_addr = 3'($urandom);
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: defaults after reset
    for (int p = 0; p < 8; p++) begin
      rd_addr = 3'(p);
      @(negedge clk);
      chk("R1", $sformatf("default pin%0d", p), rd_data, 4 + p);
    end
    cmp_en = 1;
    // R2: upper bits dropped, next-edge effect
    @(posedge clk); #1;
    wr_en = 1; wr_addr = 3; wr_data = 8'hFF; rd_addr = 3;
    @(negedge clk);
    chk("R2", "before edge", rd_data, 7);
    @(posedge clk); #1;
    wr_en = 0; dir = 8'hFF;
    @(negedge clk);
    chk("R2", "0xFF readback", rd_data, 31);
    chk("R3", "analog oe", poe[3], 0);
    chk("R3", "analog ie", pie[3], 0);
    // R11: all pins on one input function
    for (int p = 0; p < 8; p++) wr(p, 1);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1 pin = 8'(1 << i);
    end
    @(posedge clk); #1 pin = 8'h00;
    @(negedge clk);
    chk("R11", "all clear", tmr_clk, 0);
    @(posedge clk); #1 pin = 8'hA5;
    // R9: open-drain on two pins
    wr(0, 14); wr(1, 15);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1 ser_out = 6'(i * 8); ser_oe = 6'h3F;
    end
    // random phase
    for (int i = 0; i < 6000; i++) begin
      @(posedge clk); #1;
      rand_inputs();
      wr_en = ($urandom % 3) == 0;
      wr_addr = 3'($urandom);
      wr_data = ($urandom % 4 == 0) ? 8'($urandom % 19 + 224) : 8'($urandom);
    end
    @(posedge clk); #1 wr_en = 0;
    @(negedge clk);
    finish_run();
  end
endmodule